// File: doc/BRIEF.md
# NAND Flash Reset and Identification Responder

This block is the device-side control logic of a byte-wide NAND flash, cut down to its reset and identification functions. It samples the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins on a system clock. It detects strobe edges with registers and latches command and address bytes when the write strobe rises. It drives an 8-bit read bus together with an output-enable, a ready/busy output and a status byte.

A stub operation engine stands in for the array. The read (00h), program-confirm (10h) and erase-confirm (D0h) commands each keep the part busy for a configurable number of cycles. The reset command (FFh) can cut that busy period short. The identification command (90h), followed by an address byte of 00h, enters an identification mode that stays latched. In that mode successive read cycles return the maker code ECh and then the device code.

Top module: `nand_cmd_resp`

## Requirements
- R1: A command byte FFh, written while no reset is running, pulls `rdy` low within two clock cycles of the sampled write-strobe rising edge. `rdy` stays low for `T_RST` cycles and then returns high.
- R2: An FFh command written while a read, program or erase is busy ends that operation at once, so `rdy` goes high `T_RST` cycles after the reset instead of at the end of the operation.
- R3: A reset returns the command state to idle. Identification mode is left, and a read in idle returns FFh. The status byte then reads C0h with `wp_n` high. The status byte is read after command 70h: bit 7 = `wp_n`, bit 6 = `rdy`, bits 5..0 = 0.
- R4: An FFh command written while a reset countdown is still running is ignored, and the countdown is not restarted.
- R5: Command 90h followed by an address cycle (ALE high, CLE low) carrying 00h enters identification mode. Any other address value returns to idle.
- R6: In identification mode the first read cycle returns ECh and the second returns the device code `DEV_CODE` (default 75h; 35h is the other allowed value). Later reads keep alternating between the two bytes.
- R7: Identification mode persists across read cycles and idle bus time until another command is written. Writing 70h leaves it.
- R8: With `wp_n` low after a reset, the status byte reads 40h.
- R9: `io_oe` is high only while `ce_n` and `re_n` are both low. A read-strobe pulse taken with `ce_n` high does not advance the identification byte.
- R10: Commands 00h, 10h and D0h hold `rdy` low for `RD_CYC`, `PG_CYC` and `ER_CYC` cycles respectively. While `rdy` is low, every command except FFh and every address cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all strobes are sampled |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, bytes latched on its rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low; drives status bit 7 |
| io_in | input | 8 | Command and address byte from the host |
| io_out | output | 8 | Read data byte |
| io_oe | output | 1 | High when `io_out` should drive the bus |
| rdy | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest case to reach from the ports is a second FFh that lands inside a running reset countdown. A restarted countdown looks the same as a correct one unless `rdy` is sampled in the window between the original end and the restarted end. The stimulus therefore writes FFh, waits ten cycles, and writes FFh again. It then samples `rdy` three cycles after the first countdown should have ended. The abort case is built the same way: a long erase is started, FFh is written partway through, and `rdy` is checked well before the erase length would have elapsed.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
  typedef enum logic [1:0] {M_IDLE, M_ID_ADDR, M_ID, M_STATUS} mode_e;
  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_ERASE} op_e;

  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_PROG   = 8'h10;
  localparam logic [7:0] CMD_ERASE  = 8'hD0;
  localparam logic [7:0] MAKER_CODE = 8'hEC;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
endpackage

// File: rtl/nfr_strobe_sync.sv
module nfr_strobe_sync #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic          re_n,
  input  logic [DW-1:0] io_in,
  output logic          ce_n_s,
  output logic          cle_s,
  output logic          ale_s,
  output logic [DW-1:0] io_s,
  output logic          we_rise,
  output logic          re_rise
);
  logic we_s, we_d, re_s, re_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_s <= 1'b1;
      cle_s  <= 1'b0;
      ale_s  <= 1'b0;
      io_s   <= '0;
      we_s   <= 1'b1;
      we_d   <= 1'b1;
      re_s   <= 1'b1;
      re_d   <= 1'b1;
    end else begin
      ce_n_s <= ce_n;
      cle_s  <= cle;
      ale_s  <= ale;
      io_s   <= io_in;
      we_s   <= we_n;
      we_d   <= we_s;
      re_s   <= re_n;
      re_d   <= re_s;
    end
  end

  assign we_rise = we_s & ~we_d;
  assign re_rise = re_s & ~re_d;
endmodule

// File: rtl/nfr_busy_core.sv
module nfr_busy_core
  import nfr_pkg::*;
#(
  parameter int RD_CYC = 30,
  parameter int PG_CYC = 200,
  parameter int ER_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  kind,
  input  logic abort,
  output logic busy
);
  localparam int MAX1 = (RD_CYC > PG_CYC) ? RD_CYC : PG_CYC;
  localparam int MAXC = (MAX1 > ER_CYC) ? MAX1 : ER_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (abort) begin
      cnt_d = '0;
    end else if (start) begin
      case (kind)
        OP_READ:  cnt_d = CW'(RD_CYC);
        OP_PROG:  cnt_d = CW'(PG_CYC);
        default:  cnt_d = CW'(ER_CYC);
      endcase
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nfr_cmd_unit.sv
module nfr_cmd_unit
  import nfr_pkg::*;
#(
  parameter int T_RST = 100,
  localparam int RW   = $clog2(T_RST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_rise,
  input  logic          re_rise,
  input  logic          ce_n_s,
  input  logic          cle_s,
  input  logic          ale_s,
  input  logic [7:0]    io_s,
  input  logic          core_busy,
  output mode_e         mode,
  output logic          id_idx,
  output logic [RW-1:0] rst_cnt,
  output logic          resetting,
  output logic          rst_go,
  output logic          cmd_ev,
  output logic          op_start,
  output op_e           op_kind
);
  mode_e         mode_d;
  logic          idx_d;
  logic [RW-1:0] cnt_d;
  logic          addr_ev;

  assign resetting = (rst_cnt != '0);
  assign cmd_ev    = we_rise & ~ce_n_s & cle_s;
  assign addr_ev   = we_rise & ~ce_n_s & ale_s & ~cle_s;
  assign rst_go    = cmd_ev & (io_s == CMD_RESET) & ~resetting;

  always_comb begin
    mode_d   = mode;
    idx_d    = id_idx;
    cnt_d    = rst_cnt;
    op_start = 1'b0;
    op_kind  = OP_READ;
    if (rst_go) begin
      mode_d = M_IDLE;
      idx_d  = 1'b0;
      cnt_d  = RW'(T_RST);
    end else if (resetting) begin
      cnt_d = rst_cnt - 1'b1;
    end else if (!core_busy) begin
      if (cmd_ev) begin
        case (io_s)
          CMD_ID:     mode_d = M_ID_ADDR;
          CMD_STATUS: mode_d = M_STATUS;
          CMD_READ: begin
            mode_d = M_IDLE; op_start = 1'b1; op_kind = OP_READ;
          end
          CMD_PROG: begin
            mode_d = M_IDLE; op_start = 1'b1; op_kind = OP_PROG;
          end
          CMD_ERASE: begin
            mode_d = M_IDLE; op_start = 1'b1; op_kind = OP_ERASE;
          end
          default:    mode_d = M_IDLE;
        endcase
      end else if (addr_ev && mode == M_ID_ADDR) begin
        mode_d = (io_s == 8'h00) ? M_ID : M_IDLE;
        idx_d  = 1'b0;
      end else if (re_rise && !ce_n_s && mode == M_ID) begin
        idx_d = ~id_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_IDLE;
      id_idx  <= 1'b0;
      rst_cnt <= '0;
    end else begin
      mode    <= mode_d;
      id_idx  <= idx_d;
      rst_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/nand_cmd_resp.sv
module nand_cmd_resp
  import nfr_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h75,
  parameter int         T_RST    = 100,
  parameter int         RD_CYC   = 30,
  parameter int         PG_CYC   = 200,
  parameter int         ER_CYC   = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rdy
);
  localparam int RW = $clog2(T_RST + 1);

  logic          rst_m, rst_sync_n;
  logic          ce_n_s, cle_s, ale_s, we_rise, re_rise;
  logic [7:0]    io_s;
  mode_e         mode;
  logic          id_idx, resetting, rst_go, cmd_ev, op_start, core_busy;
  logic [RW-1:0] rst_cnt;
  op_e           op_kind;
  logic [7:0]    status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  nfr_strobe_sync #(.DW(8)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in), .ce_n_s(ce_n_s),
    .cle_s(cle_s), .ale_s(ale_s), .io_s(io_s), .we_rise(we_rise),
    .re_rise(re_rise)
  );

  nfr_cmd_unit #(.T_RST(T_RST)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .we_rise(we_rise), .re_rise(re_rise),
    .ce_n_s(ce_n_s), .cle_s(cle_s), .ale_s(ale_s), .io_s(io_s),
    .core_busy(core_busy), .mode(mode), .id_idx(id_idx),
    .rst_cnt(rst_cnt), .resetting(resetting), .rst_go(rst_go),
    .cmd_ev(cmd_ev), .op_start(op_start), .op_kind(op_kind)
  );

  nfr_busy_core #(.RD_CYC(RD_CYC), .PG_CYC(PG_CYC), .ER_CYC(ER_CYC)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .start(op_start), .kind(op_kind),
    .abort(rst_go), .busy(core_busy)
  );

  assign rdy    = ~resetting & ~core_busy;
  assign status = {wp_n, rdy, 6'b0};
  assign io_oe  = ~ce_n & ~re_n;

  always_comb begin
    case (mode)
      M_ID:     io_out = id_idx ? DEV_CODE : MAKER_CODE;
      M_STATUS: io_out = status;
      default:  io_out = IDLE_BYTE;
    endcase
  end
endmodule

// File: rtl/nfr_checker.sv
module nfr_checker
  import nfr_pkg::*;
#(
  parameter int RW = 7
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          rst_go,
  input logic          cmd_ev,
  input logic [7:0]    io_s,
  input logic          resetting,
  input logic [RW-1:0] rst_cnt,
  input logic          core_busy,
  input logic          rdy,
  input mode_e         mode,
  input logic          id_idx,
  input logic          io_oe,
  input logic [7:0]    io_out
);
  AST_RESET_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_go |=> !rdy); // R1
  AST_ABORT_CORE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_go |=> !core_busy); // R2
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_go |=> (mode == M_IDLE)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resetting && cmd_ev && io_s == CMD_RESET) |=> (rst_cnt < $past(rst_cnt))); // R4
  AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == M_ID && !id_idx && io_oe) |-> (io_out == MAKER_CODE)); // R6
endmodule

bind nand_cmd_resp nfr_checker #(.RW(RW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .rst_go(rst_go), .cmd_ev(cmd_ev),
  .io_s(io_s), .resetting(resetting), .rst_cnt(rst_cnt),
  .core_busy(core_busy), .rdy(rdy), .mode(mode), .id_idx(id_idx),
  .io_oe(io_oe), .io_out(io_out)
);

// File: tb/tb_nand_cmd_resp.sv
`timescale 1ns/1ps
module tb_nand_cmd_resp;
  localparam int T_RST = 40;
  localparam int RD_C  = 30;
  localparam int ER_C  = 400;

  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, we_n, re_n, wp_n;
  logic [7:0] io_in, io_out;
  logic io_oe, rdy;
  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  nand_cmd_resp #(.DEV_CODE(8'h75), .T_RST(T_RST), .RD_CYC(RD_C),
                  .PG_CYC(200), .ER_CYC(ER_C)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rdy(rdy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic is_cmd, input logic [7:0] b);
    @(negedge clk);
    ce_n = 1'b0; cle = is_cmd; ale = ~is_cmd; io_in = b; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    re_n = 1'b0;
    repeat (3) @(negedge clk);
    re_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops expected bytes while a read strobe is low
  initial begin
    forever begin
      @(negedge re_n);
      if (ce_n == 1'b0) begin
        repeat (2) @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("monitor underflow", 8'h00, 8'h01);
        end else begin
          chk({tag_q.pop_front(), " oe"}, {7'b0, io_oe}, 8'h01);
          chk(tag_q.size() >= 0 ? "read byte" : "", io_out, exp_q.pop_front());
        end
      end
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1;
    re_n = 1'b1; wp_n = 1'b1; io_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("reset state rdy R1", {7'b0, rdy}, 8'h01);
    chk("reset state oe R9", {7'b0, io_oe}, 8'h00);

    // status in idle
    wr(1'b1, 8'h70);
    rd(8'hC0, "R3 status idle");

    // identification
    wr(1'b1, 8'h90); wr(1'b0, 8'h00);
    rd(8'hEC, "R5 R6 maker");
    rd(8'h75, "R6 device");
    rd(8'hEC, "R6 wrap");
    // R9: strobe with chip disabled neither drives nor advances
    @(negedge clk); ce_n = 1'b1; re_n = 1'b0;
    @(negedge clk);
    chk("R9 oe with ce high", {7'b0, io_oe}, 8'h00);
    re_n = 1'b1; repeat (3) @(negedge clk); ce_n = 1'b0;
    repeat (20) @(negedge clk);
    rd(8'h75, "R7 R9 persist device");
    wr(1'b1, 8'h70);
    rd(8'hC0, "R7 left id");

    // bad ID address
    wr(1'b1, 8'h90); wr(1'b0, 8'h01);
    rd(8'hFF, "R5 bad address");

    // plain reset timing
    wr(1'b1, 8'hFF);
    chk("R1 busy after reset", {7'b0, rdy}, 8'h00);
    repeat (T_RST + 3) @(negedge clk);
    chk("R1 ready after tRST", {7'b0, rdy}, 8'h01);

    // second FFh during reset ignored
    wr(1'b1, 8'hFF);
    repeat (10) @(negedge clk);
    wr(1'b1, 8'hFF);
    chk("R4 busy mid reset", {7'b0, rdy}, 8'h00);
    repeat (T_RST - 13) @(negedge clk);
    chk("R4 not restarted", {7'b0, rdy}, 8'h01);

    // reset leaves ID mode
    wr(1'b1, 8'h90); wr(1'b0, 8'h00);
    wr(1'b1, 8'hFF);
    repeat (T_RST + 3) @(negedge clk);
    rd(8'hFF, "R3 id cleared");

    // read busy, commands ignored meanwhile
    wr(1'b1, 8'h00);
    chk("R10 read busy", {7'b0, rdy}, 8'h00);
    wr(1'b1, 8'h90); wr(1'b0, 8'h00);
    repeat (RD_C) @(negedge clk);
    chk("R10 read done", {7'b0, rdy}, 8'h01);
    rd(8'hFF, "R10 ignored while busy");

    // erase aborted by reset
    wr(1'b1, 8'hD0);
    repeat (60) @(negedge clk);
    chk("R10 erase busy", {7'b0, rdy}, 8'h00);
    wr(1'b1, 8'hFF);
    repeat (T_RST + 3) @(negedge clk);
    chk("R2 abort ready", {7'b0, rdy}, 8'h01);
    wr(1'b1, 8'h70);
    rd(8'hC0, "R2 R3 status after abort");

    // write protect low
    wp_n = 1'b0;
    wr(1'b1, 8'hFF);
    repeat (T_RST + 3) @(negedge clk);
    wr(1'b1, 8'h70);
    rd(8'h40, "R8 status wp low");

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) chk("queue drained", 8'h00, 8'h01);
    summary();
  end
endmodule